// File: doc/BRIEF.md
# Carry-Strength Carry-Select Adder

This block adds two unsigned operands and a carry-in, producing a sum of the operand width and a carry-out. The operands are split into fixed-size bit blocks. Inside each block, every bit position learns two things with parallel look-ahead logic: the carry it would receive if the block carry-in were zero, and whether an unbroken propagate run reaches it from the block's lowest bit. The complement of that run, the carry strength, says whether the position's carry is made inside the block. Where strength is low, the carry is taken straight from the block carry-in, so a long carry arriving at a block never ripples through it.

Each block forms both candidate sums, one for a block carry-in of zero and one for a block carry-in of one, in parallel with the carry passing between blocks. The block carry-in then only drives a select. An optional output register holds the sum and carry-out for one cycle, with an active-low asynchronous reset.

Top module: `cs_select_adder`

## Requirements
- R1: With the output register enabled, `{carry_out, sum}` equals `op_a + op_b + carry_in` of the previous clock, taken modulo 2^(WIDTH+1).
- R2: The width is a whole multiple of the 4-bit block size; an 8-bit build uses two blocks and gives correct results for every operand pair and both carry-in values.
- R3: While `rst_n` is low, `sum` and `carry_out` are zero.
- R4: A carry-in of one with full propagation (every bit position has exactly one operand bit set) yields a sum of zero and a carry-out of one.
- R5: A carry generated at bit 0 with every higher bit propagating crosses every block: `op_a = 1`, `op_b` all ones gives sum zero and carry-out one.
- R6: If both operand MSBs are one, `carry_out` is one; if both are zero, `carry_out` is zero.
- R7: Bit 0 of the sum equals `op_a[0] ^ op_b[0] ^ carry_in`.
- R8: With `op_b` zero and `carry_in` zero, `sum` equals `op_a` and `carry_out` is zero.
- R9: A carry made inside one block and leaving it through its top bit reaches the next block (for example `0x000F + 0x0001 = 0x0010`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Active-low asynchronous reset of the output register |
| op_a | input | WIDTH | First operand |
| op_b | input | WIDTH | Second operand |
| carry_in | input | 1 | Carry into bit 0 |
| sum | output | WIDTH | Sum bits |
| carry_out | output | 1 | Carry out of the most significant block |

## Verification
The two mechanisms that can meet in one cycle are the internally generated carry of a block and the carry arriving at that block from below, chosen per bit by the strength signal. Vectors such as all-ones plus one, alternating patterns with carry-in, and a carry made at bit 0 force the arriving carry to be selected across whole blocks while other blocks generate their own carries. Each result is judged against a behavioural sum of the operands one clock later, exhaustively for the 8-bit build and on random and corner vectors for the 16-bit build.

// File: rtl/cs_select_adder.sv
module cs_select_adder #(
  parameter int WIDTH   = 16,
  parameter int BLK     = 4,
  parameter bit OUT_REG = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic             carry_in,
  output logic [WIDTH-1:0] sum,
  output logic             carry_out
);
  localparam int NBLK = WIDTH / BLK;

  // carry into position k of a block with a zero block carry-in
  function automatic logic int_carry(input logic [BLK-1:0] gv, input logic [BLK-1:0] pv, input int k);
    logic acc, t;
    acc = 1'b0;
    for (int j = 0; j < BLK; j++) begin
      if (j < k) begin
        t = gv[j];
        for (int m = 0; m < BLK; m++)
          if (m > j && m < k) t = t & pv[m];
        acc = acc | t;
      end
    end
    return acc;
  endfunction

  // propagate run from the block's lowest bit up to (not including) k
  function automatic logic run_prop(input logic [BLK-1:0] pv, input int k);
    logic r;
    r = 1'b1;
    for (int m = 0; m < BLK; m++)
      if (m < k) r = r & pv[m];
    return r;
  endfunction

  logic [WIDTH-1:0] p, g, sum_c;
  logic [NBLK:0]    bc;

  assign p     = op_a ^ op_b;
  assign g     = op_a & op_b;
  assign bc[0] = carry_in;

  for (genvar b = 0; b < NBLK; b++) begin : g_blk
    logic [BLK-1:0] pb, gb, s0, s1;
    logic [BLK:0]   cint, bprop, strength;

    assign pb = p[b*BLK +: BLK];
    assign gb = g[b*BLK +: BLK];

    for (genvar k = 0; k <= BLK; k++) begin : g_cu
      assign cint[k]     = int_carry(gb, pb, k);
      assign bprop[k]    = run_prop(pb, k);
      assign strength[k] = ~bprop[k];
    end

    for (genvar k = 0; k < BLK; k++) begin : g_sg
      assign s0[k] = pb[k] ^ cint[k];
      assign s1[k] = pb[k] ^ (strength[k] ? cint[k] : 1'b1);
    end

    assign sum_c[b*BLK +: BLK] = bc[b] ? s1 : s0;
    assign bc[b+1] = cint[BLK] | (bprop[BLK] & bc[b]);
  end

  if (OUT_REG) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sum       <= '0;
        carry_out <= 1'b0;
      end else begin
        sum       <= sum_c;
        carry_out <= bc[NBLK];
      end
    end
  end else begin : g_comb
    assign sum       = sum_c;
    assign carry_out = bc[NBLK];
  end
endmodule

// File: rtl/cs_select_adder_chk.sv
module cs_select_adder_chk #(
  parameter int WIDTH   = 16,
  parameter bit OUT_REG = 1'b1
) (
  input logic             clk,
  input logic             rst_n,
  input logic [WIDTH-1:0] op_a,
  input logic [WIDTH-1:0] op_b,
  input logic             carry_in,
  input logic [WIDTH-1:0] sum,
  input logic             carry_out
);
  if (OUT_REG) begin : g_chk
    assert_total_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> {carry_out, sum} ==
        ({1'b0, $past(op_a)} + {1'b0, $past(op_b)} + {{WIDTH{1'b0}}, $past(carry_in)}));

    assert_msb_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(op_a[WIDTH-1] & op_b[WIDTH-1])) |-> carry_out);

    assert_msb_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(!(op_a[WIDTH-1] | op_b[WIDTH-1]))) |-> !carry_out);

    assert_lsb_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> sum[0] == $past(op_a[0] ^ op_b[0] ^ carry_in));

    assert_identity_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(op_b == '0 && !carry_in)) |-> (sum == $past(op_a) && !carry_out));
  end
endmodule

bind cs_select_adder cs_select_adder_chk #(.WIDTH(WIDTH), .OUT_REG(OUT_REG)) u_chk (.*);

// File: tb/cs_select_adder_tb.sv
module cs_select_adder_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] a16 = '0, b16 = '0;
  logic [7:0]  a8 = '0, b8 = '0;
  logic        c16 = 1'b0, c8 = 1'b0;
  logic [15:0] s16;
  logic [7:0]  s8;
  logic        co16, co8;

  int checks = 0;
  int errors = 0;

  logic [16:0] q16[$];
  logic [8:0]  q8[$];
  string       qtag[$];

  always #2 clk = ~clk;

  cs_select_adder #(.WIDTH(16)) u_dut (
    .clk(clk), .rst_n(rst_n), .op_a(a16), .op_b(b16), .carry_in(c16),
    .sum(s16), .carry_out(co16));

  cs_select_adder #(.WIDTH(8)) u_dut8 (
    .clk(clk), .rst_n(rst_n), .op_a(a8), .op_b(b8), .carry_in(c8),
    .sum(s8), .carry_out(co8));

  task automatic chk(string tag, logic [16:0] act, logic [16:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic compare_prev();
    if (q16.size() > 0) begin
      logic [16:0] e16;
      logic [8:0]  e8;
      string t;
      e16 = q16.pop_front();
      e8  = q8.pop_front();
      t   = qtag.pop_front();
      chk(t, {co16, s16}, e16);
      chk("R2", {8'h00, co8, s8}, {8'h00, e8});
      if (t != "R1") chk("R7", {16'h0, s16[0]}, {16'h0, e16[0]});
    end
  endtask

  task automatic step(logic [15:0] xa, logic [15:0] xb, logic xc,
                      logic [7:0] ya, logic [7:0] yb, logic yc, string tag);
    @(negedge clk);
    compare_prev();
    a16 = xa; b16 = xb; c16 = xc;
    a8 = ya; b8 = yb; c8 = yc;
    q16.push_back({1'b0, xa} + {1'b0, xb} + {16'h0, xc});
    q8.push_back({1'b0, ya} + {1'b0, yb} + {8'h0, yc});
    qtag.push_back(tag);
  endtask

  task automatic corner(logic [15:0] xa, logic [15:0] xb, logic xc, string tag);
    step(xa, xb, xc, 8'h00, 8'h00, 1'b0, tag);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #700000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    a16 = 16'hFFFF; b16 = 16'hFFFF; c16 = 1'b1;
    repeat (3) @(negedge clk);
    chk("R3", {co16, s16}, 17'h0);
    chk("R3", {8'h00, co8, s8}, 17'h0);
    rst_n = 1'b1;

    for (int i = 0; i < 512; i++)
      for (int j = 0; j < 256; j++)
        step(16'($urandom), 16'($urandom), 1'($urandom),
             i[7:0], j[7:0], i[8], "R1");

    corner(16'hFFFF, 16'h0001, 1'b0, "R5");
    corner(16'h0001, 16'hFFFF, 1'b0, "R5");
    corner(16'h0000, 16'hFFFF, 1'b1, "R4");
    corner(16'hAAAA, 16'h5555, 1'b1, "R4");
    corner(16'h5555, 16'hAAAA, 1'b0, "R4");
    corner(16'h5555, 16'h5555, 1'b0, "R1");
    corner(16'hAAAA, 16'hAAAA, 1'b1, "R1");
    corner(16'h8000, 16'h8000, 1'b0, "R6");
    corner(16'hC001, 16'h8FFF, 1'b1, "R6");
    corner(16'h7FFF, 16'h0000, 1'b1, "R6");
    corner(16'h7FFF, 16'h7FFF, 1'b1, "R6");
    corner(16'h1234, 16'h0000, 1'b0, "R8");
    corner(16'hFFFF, 16'h0000, 1'b0, "R8");
    corner(16'h000F, 16'h0001, 1'b0, "R9");
    corner(16'h0F00, 16'h0100, 1'b0, "R9");
    corner(16'h00F0, 16'h0000, 1'b1, "R9");
    corner(16'h0007, 16'h0008, 1'b1, "R9");
    for (int i = 0; i < 1000; i++)
      corner(16'($urandom), 16'($urandom), 1'($urandom), "R1");
    @(negedge clk);
    compare_prev();

    a16 = 16'hFFFF; b16 = 16'h0001; c16 = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R3", {co16, s16}, 17'h0);
    chk("R3", {8'h00, co8, s8}, 17'h0);
    finish_run();
  end
endmodule